// File: doc/BRIEF.md
# Priority Flow Control Pause Transmitter

This block builds a priority-based pause frame and sends it as a byte stream whenever software raises a one-cycle request. The frame carries the reserved multicast destination 01-80-C2-00-00-01, the station address as source, the MAC control type and the priority pause opcode, a two-byte priority enable vector and eight two-byte pause times. It is zero padded to the 60-byte minimum length that precedes the FCS. FCS and line coding are added further down the transmit chain.

The block sits between the normal transmit path and the rest of the transmit chain. Ordinary data frames pass straight through it. A pause frame is placed on the line at once when the line is idle. When a data frame is being sent, the pause frame waits until that frame ends and then goes out before the next data frame. The configuration is captured when the request is accepted. A `pause_done` pulse marks completion.

Top module: `pfc_pause_tx`

## Requirements
- R1: A one-cycle `pause_req` is accepted when `full_duplex` and `tx_enable` are both high in that cycle. An accepted request produces exactly one pause frame on the output stream.
- R2: A request made while `full_duplex` or `tx_enable` is low is dropped. No byte is emitted for it.
- R3: Bytes 0..5 of the frame are 01 80 C2 00 00 01. Bytes 6..11 are `station_addr` with bits [47:40] first. Bytes 12..13 are 88 08 and bytes 14..15 are 01 01.
- R4: Byte 16 is 00 and byte 17 is `prio_enable`. Pause time k is `pause_times[16k+15:16k]`. It occupies bytes 18+2k (high byte) and 19+2k (low byte), for k = 0..7.
- R5: The frame is exactly 60 bytes long and bytes 34..59 are zero. `out_sof` is high only on byte 0 and `out_eof` is high only on byte 59.
- R6: When the output is idle and `out_ready` is high, byte 0 is transferred in the cycle after the accepting edge.
- R7: A request made during a data frame is held until the data byte carrying `dat_eof` has been transferred. The pause frame then goes out before any byte of the next data frame, and `dat_ready` stays low while the pause frame is being sent.
- R8: The address, enable vector and pause times are captured at acceptance. Changes to these inputs afterwards do not alter the frame.
- R9: A request that arrives while a pause frame is pending or in progress is merged into it. It produces no second frame and no second done pulse.
- R10: `pause_done` is high for one cycle, in the cycle after byte 59 is transferred.
- R11: With no pause frame pending, data bytes, `dat_sof` and `dat_eof` appear unchanged on the output, and `dat_ready` follows `out_ready`.
- R12: While `out_ready` is low, the pause byte on the output is held and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pause_req | input | 1 | One-cycle request for a pause frame |
| full_duplex | input | 1 | Link is in full duplex |
| tx_enable | input | 1 | Transmitter enabled |
| station_addr | input | 48 | Source address, bits [47:40] sent first |
| prio_enable | input | 8 | Per-priority pause enable bits |
| pause_times | input | 128 | Eight pause times, time k at [16k+15:16k] |
| dat_valid | input | 1 | Data path byte valid |
| dat_data | input | 8 | Data path byte |
| dat_sof | input | 1 | First byte of a data frame |
| dat_eof | input | 1 | Last byte of a data frame |
| dat_ready | output | 1 | Data path byte accepted |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of an output frame |
| out_eof | output | 1 | Last byte of an output frame |
| out_ready | input | 1 | Downstream accepts the byte |
| pause_done | output | 1 | One-cycle pulse after the last pause byte |

## Verification
Corrupted byte-index or capture state shows on the output within one frame time. It appears as a misplaced marker, a wrong header byte or a frame that is not 60 bytes long. A stuck pending flag appears at once as repeated frames or as a data path that never regains `dat_ready`. A wrong arbiter state lets a data byte appear inside a pause frame, or lets a pause byte appear inside a data frame, at the very next handshake. The bench sweeps several configuration patterns, enable combinations, random backpressure and mid-frame requests, and compares every output byte against a frame image it builds arithmetically.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NPRIO     = 8;
  localparam int HDR_BYTES = 18 + 2 * NPRIO;
  localparam logic [47:0] PFC_DST = 48'h0180C2000001;

  typedef enum logic [1:0] {ARB_IDLE, ARB_DATA, ARB_PAUSE} arb_st_t;

  // Byte idx of a pause frame; everything past the header is padding.
  function automatic logic [7:0] frame_byte(input int unsigned idx,
                                            input logic [47:0] sa,
                                            input logic [7:0] pen,
                                            input logic [16*NPRIO-1:0] pt);
    int unsigned k;
    logic [15:0] w;
    if (idx < 6) return PFC_DST[47 - 8*idx -: 8];
    if (idx < 12) return sa[47 - 8*(idx - 6) -: 8];
    case (idx)
      12: return 8'h88;
      13: return 8'h08;
      14: return 8'h01;
      15: return 8'h01;
      16: return 8'h00;
      17: return pen;
      default: ;
    endcase
    if (idx < HDR_BYTES) begin
      k = (idx - 18) / 2;
      w = pt[16*k +: 16];
      return ((idx % 2) == 0) ? w[15:8] : w[7:0];
    end
    return 8'h00;
  endfunction
endpackage

// File: rtl/pfc_req_ctrl.sv
module pfc_req_ctrl
  import pfc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pause_req,
  input  logic                  full_duplex,
  input  logic                  tx_enable,
  input  logic [47:0]           station_addr,
  input  logic [7:0]            prio_enable,
  input  logic [16*NPRIO-1:0]   pause_times,
  input  logic                  frame_end,
  output logic                  armed,
  output logic [47:0]           cap_sa,
  output logic [7:0]            cap_pen,
  output logic [16*NPRIO-1:0]   cap_pt
);
  logic req_accept;
  assign req_accept = pause_req && full_duplex && tx_enable && !armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      cap_sa  <= '0;
      cap_pen <= '0;
      cap_pt  <= '0;
    end else if (req_accept) begin
      armed   <= 1'b1;
      cap_sa  <= station_addr;
      cap_pen <= prio_enable;
      cap_pt  <= pause_times;
    end else if (frame_end) begin
      armed   <= 1'b0;
    end
  end

  // R1: a qualified request arms the transmitter
  a_r1_accept_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_req && full_duplex && tx_enable && !armed) |=> armed);
  // R2: without both enables, an idle controller stays idle
  a_r2_drop_unqualified: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(pause_req && full_duplex && tx_enable)) |=> !armed);
  // R8: captured configuration does not move while armed
  a_r8_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(cap_sa) && $stable(cap_pen) && $stable(cap_pt)));
  // R9: a request while armed does not end the pending frame
  a_r9_merge: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !frame_end) |=> armed);
endmodule

// File: rtl/pfc_frame_gen.sv
module pfc_frame_gen
  import pfc_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  advance,
  input  logic [47:0]           cap_sa,
  input  logic [7:0]            cap_pen,
  input  logic [16*NPRIO-1:0]   cap_pt,
  output logic [7:0]            byte_o,
  output logic                  first_o,
  output logic                  last_o,
  output logic                  frame_end,
  output logic                  pause_done
);
  localparam int IW = $clog2(FRAME_LEN);

  logic [IW-1:0] idx_q;

  assign first_o   = (idx_q == '0);
  assign last_o    = (idx_q == IW'(FRAME_LEN - 1));
  assign frame_end = advance && last_o;
  assign byte_o    = frame_byte(32'(idx_q), cap_sa, cap_pen, cap_pt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q      <= '0;
      pause_done <= 1'b0;
    end else begin
      pause_done <= frame_end;
      if (advance) idx_q <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  // R5: index never leaves the frame
  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx_q) < FRAME_LEN);
  // R10: done follows the last transfer and leaves the index rewound
  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pause_done && idx_q == '0));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |=> !pause_done);
endmodule

// File: rtl/pfc_tx_arb.sv
module pfc_tx_arb
  import pfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic [7:0] pause_byte,
  input  logic       pause_first,
  input  logic       pause_last,
  input  logic       dat_valid,
  input  logic [7:0] dat_data,
  input  logic       dat_sof,
  input  logic       dat_eof,
  output logic       dat_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  input  logic       out_ready,
  output logic       pause_adv
);
  arb_st_t st_q, st_d;
  logic    sel_pause, sel_data, dat_xfer;

  assign sel_pause = (st_q == ARB_PAUSE) || (st_q == ARB_IDLE && armed);
  assign sel_data  = !sel_pause;
  assign pause_adv = sel_pause && out_ready;
  assign dat_ready = sel_data && out_ready;
  assign dat_xfer  = dat_ready && dat_valid;

  always_comb begin
    out_valid = sel_pause ? 1'b1        : dat_valid;
    out_data  = sel_pause ? pause_byte  : dat_data;
    out_sof   = sel_pause ? pause_first : dat_sof;
    out_eof   = sel_pause ? pause_last  : dat_eof;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ARB_IDLE:  if (armed) st_d = (pause_adv && pause_last) ? ARB_IDLE : ARB_PAUSE;
                 else if (dat_xfer && !dat_eof) st_d = ARB_DATA;
      ARB_DATA:  if (dat_xfer && dat_eof) st_d = ARB_IDLE;
      ARB_PAUSE: if (pause_adv && pause_last) st_d = ARB_IDLE;
      default:   st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  // R7: data path is held off while a pause frame is on the line
  a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_PAUSE) |-> !dat_ready);
  // R7: a data frame in flight is never pre-empted
  a_r7_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_DATA) |-> !pause_adv);
  // R12: stalled pause byte is held
  a_r12_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ARB_PAUSE && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof)));
endmodule

// File: rtl/pfc_pause_tx.sv
module pfc_pause_tx
  import pfc_pkg::*;
#(
  parameter int FRAME_LEN = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pause_req,
  input  logic                full_duplex,
  input  logic                tx_enable,
  input  logic [47:0]         station_addr,
  input  logic [7:0]          prio_enable,
  input  logic [16*NPRIO-1:0] pause_times,
  input  logic                dat_valid,
  input  logic [7:0]          dat_data,
  input  logic                dat_sof,
  input  logic                dat_eof,
  output logic                dat_ready,
  output logic                out_valid,
  output logic [7:0]          out_data,
  output logic                out_sof,
  output logic                out_eof,
  input  logic                out_ready,
  output logic                pause_done
);
  logic                armed, frame_end, pause_adv, p_first, p_last;
  logic [7:0]          p_byte, cap_pen;
  logic [47:0]         cap_sa;
  logic [16*NPRIO-1:0] cap_pt;

  pfc_req_ctrl u_req (
    .clk, .rst_n, .pause_req, .full_duplex, .tx_enable,
    .station_addr, .prio_enable, .pause_times,
    .frame_end, .armed, .cap_sa, .cap_pen, .cap_pt
  );

  pfc_frame_gen #(.FRAME_LEN(FRAME_LEN)) u_gen (
    .clk, .rst_n, .advance(pause_adv), .cap_sa, .cap_pen, .cap_pt,
    .byte_o(p_byte), .first_o(p_first), .last_o(p_last),
    .frame_end, .pause_done
  );

  pfc_tx_arb u_arb (
    .clk, .rst_n, .armed, .pause_byte(p_byte), .pause_first(p_first),
    .pause_last(p_last), .dat_valid, .dat_data, .dat_sof, .dat_eof,
    .dat_ready, .out_valid, .out_data, .out_sof, .out_eof, .out_ready,
    .pause_adv
  );

  // R10: completion only ever follows an armed frame
  a_r10_done_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    pause_done |-> $past(armed));
endmodule

// File: tb/tb_pfc_pause_tx.sv
module tb_pfc_pause_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pause_req = 0, full_duplex = 1, tx_enable = 1;
  logic [47:0] station_addr = '0;
  logic [7:0] prio_enable = '0;
  logic [127:0] pause_times = '0;
  logic dat_valid = 0, dat_sof = 0, dat_eof = 0, out_ready = 1;
  logic [7:0] dat_data = '0;
  logic dat_ready, out_valid, out_sof, out_eof, pause_done;
  logic [7:0] out_data;

  pfc_pause_tx dut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Backpressure generator (R12)
  bit bp_on = 0;
  logic [7:0] lfsr = 8'h5A;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  // Output monitor
  logic [7:0] rx_b [0:1023];
  logic       rx_s [0:1023];
  logic       rx_e [0:1023];
  int         rx_c [0:1023];
  int rx_n = 0, done_n = 0, done_cyc = 0;
  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready && rx_n < 1024) begin
      rx_b[rx_n] = out_data; rx_s[rx_n] = out_sof;
      rx_e[rx_n] = out_eof;  rx_c[rx_n] = cyc;
      rx_n++;
    end
    if (pause_done) begin done_n++; done_cyc = cyc; end
  end

  int tests = 0, fails = 0;
  bit ended = 0;
  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int i, logic [47:0] sa, logic [7:0] pen, logic [127:0] pt);
    logic [271:0] img;
    img[271:128] = {48'h0180C2000001, sa, 16'h8808, 16'h0101, 8'h00, pen};
    for (int k = 0; k < 8; k++) img[127 - 16*k -: 16] = pt[16*k +: 16];
    if (i < 34) return img[271 - 8*i -: 8];
    return 8'h00;
  endfunction

  // Compare one recorded pause frame; returns first bad index or -1
  function automatic int frame_err(int base, logic [47:0] sa, logic [7:0] pen, logic [127:0] pt);
    for (int i = 0; i < 60; i++)
      if (rx_b[base+i] !== exp_byte(i, sa, pen, pt) || rx_s[base+i] !== (i == 0) ||
          rx_e[base+i] !== (i == 59)) return i;
    return -1;
  endfunction

  task automatic pulse_req();
    @(posedge clk); #1; pause_req = 1;
    @(posedge clk); #1; pause_req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_bytes(int target);
    for (int t = 0; t < 2000 && rx_n < target; t++) @(posedge clk);
    #1;
  endtask

  task automatic run_pause(logic [47:0] sa, logic [7:0] pen, logic [127:0] pt, bit bp);
    int base, d0, rc, e;
    station_addr = sa; prio_enable = pen; pause_times = pt; bp_on = bp;
    base = rx_n; d0 = done_n;
    @(posedge clk); #1; rc = cyc; pause_req = 1;
    @(posedge clk); #1; pause_req = 0;
    wait_bytes(base + 60);
    idle(20);
    bp_on = 0;
    if (!bp) chk(rx_c[base] == rc + 1, "R6 first byte latency", rx_c[base], rc + 1);
    chk(rx_n - base == 60, "R1/R5 frame length", rx_n - base, 60);
    e = frame_err(base, sa, pen, pt);
    chk(e < 0, bp ? "R12 content under backpressure" : "R3/R4/R5 frame content", e, -1);
    chk(done_n - d0 == 1, "R10 done count", done_n - d0, 1);
    chk(done_cyc == rx_c[base+59] + 1, "R10 done timing", done_cyc, rx_c[base+59] + 1);
  endtask

  task automatic send_data(int len, logic [7:0] b0);
    bit ok;
    for (int i = 0; i < len; i++) begin
      dat_valid = 1; dat_data = b0 + 8'(i); dat_sof = (i == 0); dat_eof = (i == len - 1);
      do begin
        @(negedge clk); ok = dat_ready;
        @(posedge clk); #1;
      end while (!ok);
    end
    dat_valid = 0; dat_sof = 0; dat_eof = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1; fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int base, d0, e;
    logic [127:0] pt_a;
    idle(4); rst_n = 1; idle(2);
    // Reset state
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
    chk(pause_done == 0, "R10 reset done", pause_done, 0);
    chk(dat_ready == out_ready, "R11 ready passthrough", dat_ready, out_ready);

    // R2: every disabled combination drops the request
    for (int c = 0; c < 3; c++) begin
      full_duplex = c[1]; tx_enable = c[0];
      base = rx_n; d0 = done_n;
      pulse_req(); idle(80);
      chk(rx_n == base, "R2 dropped request bytes", rx_n - base, 0);
      chk(done_n == d0, "R2 dropped request done", done_n - d0, 0);
    end
    full_duplex = 1; tx_enable = 1;

    // R1/R3/R4/R5/R6/R10 over several configuration patterns
    for (int p = 0; p < 5; p++) begin
      logic [127:0] pt;
      for (int k = 0; k < 8; k++) pt[16*k +: 16] = 16'(p * 16'h1111 + k * 16'h0203 + (k << 12));
      run_pause(48'hA1B2C3D4E5F6 ^ {6{8'(p * 37)}}, 8'(1 << p) | 8'(p * 3), pt, 0);
    end
    run_pause(48'hFFFFFFFFFFFF, 8'hFF, {128{1'b1}}, 0);
    run_pause(48'h0, 8'h00, '0, 0);
    // R12: random backpressure
    run_pause(48'h0200DEADBEEF, 8'h96, {8{16'hC3A5}}, 1);

    // R8: config changed right after acceptance
    pt_a = {8{16'h1234}};
    station_addr = 48'h020304050607; prio_enable = 8'h3C; pause_times = pt_a;
    base = rx_n;
    @(posedge clk); #1; pause_req = 1;
    @(posedge clk); #1; pause_req = 0;
    station_addr = 48'hFFEEDDCCBBAA; prio_enable = 8'h01; pause_times = '1;
    wait_bytes(base + 60); idle(10);
    e = frame_err(base, 48'h020304050607, 8'h3C, pt_a);
    chk(e < 0, "R8 captured config", e, -1);

    // R9: second request during the frame is merged
    station_addr = 48'h0A0B0C0D0E0F; prio_enable = 8'h81; pause_times = pt_a;
    base = rx_n; d0 = done_n;
    pulse_req(); idle(10); pulse_req(); idle(200);
    chk(rx_n - base == 60, "R9 merged request length", rx_n - base, 60);
    chk(done_n - d0 == 1, "R9 merged request done", done_n - d0, 1);

    // R7/R11: request during a data frame, another data frame queued
    base = rx_n;
    fork
      begin send_data(10, 8'h40); send_data(8, 8'hA0); end
      begin wait (rx_n >= base + 3); pulse_req(); end
    join
    idle(100);
    chk(rx_n - base == 78, "R7 stream length", rx_n - base, 78);
    e = -1;
    for (int i = 0; i < 10; i++)
      if (e < 0 && (rx_b[base+i] !== 8'(8'h40 + i) || rx_s[base+i] !== (i == 0) || rx_e[base+i] !== (i == 9))) e = i;
    chk(e < 0, "R11 data frame passthrough", e, -1);
    e = frame_err(base + 10, 48'h0A0B0C0D0E0F, 8'h81, pt_a);
    chk(e < 0, "R7 pause inserted after data eof", e, -1);
    e = -1;
    for (int i = 0; i < 8; i++)
      if (e < 0 && (rx_b[base+70+i] !== 8'(8'hA0 + i) || rx_s[base+70+i] !== (i == 0))) e = i;
    chk(e < 0, "R7 next data frame after pause", e, -1);

    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule